// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer

This block is an 8-bit counter with three ways of working, picked by a two-bit mode field in its control register. In reload mode it counts up from a programmable start value. Each time it steps past 0xFF it reloads that start value and raises an overflow flag. In capture mode it counts the same way, and a rising edge on a trigger pin copies the running count into a result register. In measurement mode it counts rising edges of the external clock pin while a reference gate pin is high. When the gate drops, the total is stored and a done flag is raised.

For the two counting modes, the step comes either from an internal prescaler that divides the block clock by `PRE_DIV`, or from rising edges of the external clock pin. All three pins are brought into the clock domain through a flip-flop chain. A small register port on the block clock gives access to the control, reload, live count, result and status values. The overflow flag can be driven onto a pin, and a masked OR of the three flags forms the interrupt request.

The control state machine has five states. `ST_IDLE` holds the count. `ST_RELOAD` counts with reload. `ST_CAPT` counts and accepts capture triggers. `ST_MWAIT` waits for the gate to rise. `ST_MGATE` counts measured edges while the gate is high. The transitions are:
- Start: from `ST_IDLE` when run is set. Mode 0 goes to `ST_RELOAD`, mode 1 to `ST_CAPT`, mode 2 to `ST_MWAIT`. Mode 3 stays in `ST_IDLE`.
- Open: `ST_MWAIT` to `ST_MGATE` on a gate rise.
- Close: `ST_MGATE` back to `ST_MWAIT` on a gate fall.
- Stop: from any running state back to `ST_IDLE` when run is cleared or the mode field no longer matches the state.

Top module: `tmr8_multimode`

## Requirements
- R1: After reset, all five readable registers read 0, and `ovf_pin` and `irq` are low.
- R2: The register map is: 0 control, 1 reload, 2 live count, 3 result, 4 status. Control bits are: [1:0] mode, [2] external step source, [3] run, [4] overflow pin enable, [7:5] interrupt enables for overflow, capture and done. Starting mode 0 or 1 loads the count from the reload register. With bit 2 set, each rising edge of `ext_clk` then adds exactly one.
- R3: In modes 0 and 1, a step taken while the count is 0xFF loads the reload value and sets status bit 0 (overflow).
- R4: With bit 2 clear, the count steps once every `PRE_DIV` clock cycles while running.
- R5: In mode 1, a rising edge of `cap_trig` copies the live count into the result register and sets status bit 1. Counting carries on.
- R6: Outside mode 1, edges on `cap_trig` change neither the result register nor status bit 1.
- R7: In mode 2, the count is cleared when `ref_gate` rises. It counts rising edges of `ext_clk` while the gate is high. On the gate's fall the count is copied to the result register and status bit 2 is set. Edges while the gate is low are not counted.
- R8: In mode 2 the count stops at 0xFF rather than wrapping.
- R9: Writing 1 to a status bit at address 4 clears it. If a flag's set event lands in the same cycle as its clear, the flag ends up set.
- R10: `ovf_pin` follows status bit 0 when control bit 4 is set, and is low otherwise.
- R11: `irq` is high when any status bit is set together with its enable bit in control [7:5].
- R12: With run clear, the live count holds its value whatever the step pins do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| ext_clk | input | 1 | External step clock, also the measured clock |
| cap_trig | input | 1 | Capture trigger pin |
| ref_gate | input | 1 | Reference gate for measurement mode |
| ovf_pin | output | 1 | Overflow flag pin output |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `PRE_DIV` at 4 and a two-stage synchroniser. With that divider, overflow from the internal prescaler happens within a few tens of cycles. A reload value of 0xFF then gives an overflow every fourth cycle, so a held status clear can be made to coincide with set events. The 8-bit limit in measurement mode is reached with 300 gated pulses. The reload wrap is reached with three external pulses from a start value of 0xFD.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        MODE_RELOAD  = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_MEASURE = 2'd2,
        MODE_RSVD    = 2'd3
    } tmr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RELOAD = 3'd1,
        ST_CAPT   = 3'd2,
        ST_MWAIT  = 3'd3,
        ST_MGATE  = 3'd4
    } tmr_state_e;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_RELOAD = 3'd1;
    localparam logic [2:0] ADDR_COUNT  = 3'd2;
    localparam logic [2:0] ADDR_RESULT = 3'd3;
    localparam logic [2:0] ADDR_STATUS = 3'd4;

    localparam int CTL_EXT = 2;
    localparam int CTL_RUN = 3;
    localparam int CTL_PIN = 4;
    localparam int CTL_IE0 = 5;

    localparam int FLG_OVF  = 0;
    localparam int FLG_CAP  = 1;
    localparam int FLG_DONE = 2;
    localparam int FLG_N    = 3;
endpackage

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-1:0], din[i]};
        end
        assign level[i] = sh[STAGES-1];
        assign rise[i]  = sh[STAGES-1] & ~sh[STAGES];
        assign fall[i]  = ~sh[STAGES-1] & sh[STAGES];
    end
endmodule

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    if (DIV <= 1) begin : g_bypass
        logic unused_ok;
        assign unused_ok = clk ^ rst_n;
        assign tick = en;
    end else begin : g_div
        localparam int PW = $clog2(DIV);
        localparam logic [PW-1:0] LAST = PW'(DIV - 1);
        logic [PW-1:0] cnt;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (!en)         cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
        end
        assign tick = en && (cnt == LAST);
    end
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  tmr_mode_e        mode,
    input  logic             tick,
    input  logic             meas_edge,
    input  logic             gate_rise,
    input  logic             gate_fall,
    input  logic             cap_edge,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] result,
    output logic             ovf_evt,
    output logic             cap_evt,
    output logic             done_evt
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    tmr_state_e state, nxt;
    logic       mode_ok, keep, at_max;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_RELOAD:          mode_ok = (mode == MODE_RELOAD);
            ST_CAPT:            mode_ok = (mode == MODE_CAPTURE);
            ST_MWAIT, ST_MGATE: mode_ok = (mode == MODE_MEASURE);
            default:            mode_ok = 1'b1;
        endcase
    end
    assign keep   = run && mode_ok;
    assign at_max = (count == MAXV);

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (run) begin
                    unique case (mode)
                        MODE_RELOAD:  nxt = ST_RELOAD;
                        MODE_CAPTURE: nxt = ST_CAPT;
                        MODE_MEASURE: nxt = ST_MWAIT;
                        default:      nxt = ST_IDLE;
                    endcase
                end
            end
            ST_RELOAD, ST_CAPT: if (!keep) nxt = ST_IDLE;
            ST_MWAIT: begin
                if (!keep)          nxt = ST_IDLE;
                else if (gate_rise) nxt = ST_MGATE;
            end
            ST_MGATE: begin
                if (!keep)          nxt = ST_IDLE;
                else if (gate_fall) nxt = ST_MWAIT;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // output events
    always_comb begin
        ovf_evt  = 1'b0;
        cap_evt  = 1'b0;
        done_evt = 1'b0;
        unique case (state)
            ST_RELOAD: ovf_evt = keep && tick && at_max;
            ST_CAPT: begin
                ovf_evt = keep && tick && at_max;
                cap_evt = keep && cap_edge;
            end
            ST_MGATE: done_evt = keep && gate_fall;
            default: ;
        endcase
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (run && mode != MODE_RSVD) count <= reload;
                ST_RELOAD, ST_CAPT: begin
                    if (keep && tick) count <= at_max ? reload : count + 1'b1;
                end
                ST_MWAIT: if (keep && gate_rise) count <= '0;
                ST_MGATE: if (keep && meas_edge && !at_max) count <= count + 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   result <= '0;
        else if (cap_evt || done_evt) result <= count;
    end

    p_wrap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (count == $past(reload)));
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !run) |=> $stable(count));
    p_capture_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (result == $past(count)));
    p_meas_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MGATE && at_max) |=> (count == MAXV));
endmodule

// File: rtl/tmr8_multimode.sv
module tmr8_multimode
    import tmr8_pkg::*;
#(
    parameter int PRE_DIV     = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       ext_clk,
    input  logic       cap_trig,
    input  logic       ref_gate,
    output logic       ovf_pin,
    output logic       irq
);
    logic [7:0]       ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [FLG_N-1:0] sts_q, sts_set, sts_clr;
    logic [2:0]       pin_lvl, pin_rise, pin_fall;
    logic [CNT_W-1:0] count, result;
    logic             ovf_evt, cap_evt, done_evt;
    logic             pre_tick, step, run, ext_sel, pre_en;
    tmr_mode_e        mode;

    assign mode    = tmr_mode_e'(ctrl_q[1:0]);
    assign ext_sel = ctrl_q[CTL_EXT];
    assign run     = ctrl_q[CTL_RUN];
    assign pre_en  = run && !ext_sel && (mode == MODE_RELOAD || mode == MODE_CAPTURE);

    // bit 0 ext_clk, bit 1 cap_trig, bit 2 ref_gate
    tmr8_edge_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ref_gate, cap_trig, ext_clk}),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    tmr8_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pre_en),
        .tick  (pre_tick)
    );

    assign step = ext_sel ? pin_rise[0] : pre_tick;

    tmr8_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mode      (mode),
        .tick      (step),
        .meas_edge (pin_rise[0]),
        .gate_rise (pin_rise[2]),
        .gate_fall (pin_fall[2]),
        .cap_edge  (pin_rise[1]),
        .reload    (reload_q),
        .count     (count),
        .result    (result),
        .ovf_evt   (ovf_evt),
        .cap_evt   (cap_evt),
        .done_evt  (done_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL)   ctrl_q   <= wr_data;
            if (wr_addr == ADDR_RELOAD) reload_q <= wr_data;
        end
    end

    assign sts_set = {done_evt, cap_evt, ovf_evt};
    assign sts_clr = (wr_en && wr_addr == ADDR_STATUS) ? wr_data[FLG_N-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~sts_clr) | sts_set;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL:   rd_data = ctrl_q;
            ADDR_RELOAD: rd_data = reload_q;
            ADDR_COUNT:  rd_data = count;
            ADDR_RESULT: rd_data = result;
            ADDR_STATUS: rd_data = {{(8-FLG_N){1'b0}}, sts_q};
            default:     rd_data = '0;
        endcase
    end

    assign ovf_pin = ctrl_q[CTL_PIN] & sts_q[FLG_OVF];
    assign irq     = |(sts_q & ctrl_q[CTL_IE0 +: FLG_N]);

    logic unused_lvl;
    assign unused_lvl = ^pin_lvl;

    p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> sts_q[FLG_OVF]);
    p_cap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> sts_q[FLG_CAP]);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && sts_clr[FLG_DONE]) |=> sts_q[FLG_DONE]);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr[FLG_CAP] && !cap_evt) |=> !sts_q[FLG_CAP]);
endmodule

// File: tb/sim_tmr8_multimode.sv
`timescale 1ns/1ps
module sim_tmr8_multimode;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_clk = 1'b0, cap_trig = 1'b0, ref_gate = 1'b0;
    logic       ovf_pin, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tmr8_multimode #(.PRE_DIV(4), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_clk(ext_clk), .cap_trig(cap_trig), .ref_gate(ref_gate),
        .ovf_pin(ovf_pin), .irq(irq)
    );

    // scoreboard item: src 0..4 register address, 5 ovf_pin, 6 irq
    typedef struct {
        int         src;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];
    event  mon_go;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares with what the design shows
    initial begin
        forever begin
            @(mon_go);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                if (it.src < 5)       act = rd_data;
                else if (it.src == 5) act = {7'd0, ovf_pin};
                else                  act = {7'd0, irq};
                check(it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int src, input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        if (src < 5) rd_addr = 3'(src);
        it.src = src; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> mon_go;
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; repeat (4) @(negedge clk);
            ext_clk = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    task automatic trig_pulse();
        cap_trig = 1'b1; repeat (4) @(negedge clk);
        cap_trig = 1'b0; repeat (4) @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 5; a++) expect_item(a, 8'h00, "R1 reset register");
        expect_item(5, 8'h00, "R1 reset ovf_pin");
        expect_item(6, 8'h00, "R1 reset irq");

        // R2 / R3 / R10 / R11: reload mode, external steps
        wr(3'd1, 8'hFD);
        wr(3'd0, 8'h3C);
        repeat (3) @(negedge clk);
        expect_item(2, 8'hFD, "R2 start loads reload");
        ext_pulses(1);
        expect_item(2, 8'hFE, "R2 one step per ext edge");
        ext_pulses(1);
        expect_item(2, 8'hFF, "R2 second step");
        expect_item(4, 8'h00, "R3 no overflow before wrap");
        ext_pulses(1);
        expect_item(2, 8'hFD, "R3 wrap loads reload");
        expect_item(4, 8'h01, "R3 overflow flag set");
        expect_item(5, 8'h01, "R10 pin follows flag");
        expect_item(6, 8'h01, "R11 irq with enable");
        wr(3'd4, 8'h01);
        expect_item(4, 8'h00, "R9 write one clears");
        expect_item(6, 8'h00, "R11 irq drops with flag");
        wr(3'd0, 8'h2C);
        ext_pulses(3);
        expect_item(4, 8'h01, "R3 second overflow");
        expect_item(5, 8'h00, "R10 pin masked when disabled");
        expect_item(6, 8'h01, "R11 irq still enabled");
        wr(3'd0, 8'h0C);
        expect_item(6, 8'h00, "R11 irq masked");

        // R12 stopped
        wr(3'd0, 8'h04);
        ext_pulses(2);
        expect_item(2, 8'hFD, "R12 count holds when stopped");

        // R4 internal prescaler
        wr(3'd4, 8'h07);
        wr(3'd1, 8'hFC);
        wr(3'd0, 8'h08);
        repeat (6) @(negedge clk);
        expect_item(4, 8'h00, "R4 no overflow before four divided steps");
        repeat (24) @(negedge clk);
        expect_item(4, 8'h01, "R4 overflow after divided steps");
        wr(3'd0, 8'h00);

        // R5 capture mode
        wr(3'd4, 8'h07);
        wr(3'd1, 8'h10);
        wr(3'd0, 8'h0D);
        repeat (3) @(negedge clk);
        ext_pulses(3);
        expect_item(2, 8'h13, "R5 counting before trigger");
        trig_pulse();
        expect_item(3, 8'h13, "R5 capture copies count");
        expect_item(4, 8'h02, "R5 capture flag");
        ext_pulses(2);
        expect_item(2, 8'h15, "R5 counting continues");
        expect_item(3, 8'h13, "R5 result stable");

        // R6 trigger ignored outside capture mode
        wr(3'd0, 8'h0C);
        wr(3'd4, 8'h02);
        trig_pulse();
        expect_item(3, 8'h13, "R6 result untouched in reload mode");
        expect_item(4, 8'h00, "R6 no capture flag in reload mode");

        // R7 measurement
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h07);
        wr(3'd0, 8'h0A);
        repeat (4) @(negedge clk);
        ref_gate = 1'b1; repeat (8) @(negedge clk);
        ext_pulses(5);
        ref_gate = 1'b0; repeat (8) @(negedge clk);
        expect_item(3, 8'h05, "R7 gated edge total");
        expect_item(4, 8'h04, "R7 done flag");
        ext_pulses(3);
        expect_item(2, 8'h05, "R7 no count with gate low");
        expect_item(3, 8'h05, "R7 result kept with gate low");

        // R8 saturation
        wr(3'd4, 8'h07);
        ref_gate = 1'b1; repeat (8) @(negedge clk);
        ext_pulses(300);
        ref_gate = 1'b0; repeat (8) @(negedge clk);
        expect_item(3, 8'hFF, "R8 count stops at limit");
        expect_item(4, 8'h04, "R8 done flag");

        // R9 set wins over simultaneous clear
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h07);
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h18);
        repeat (4) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
        hits = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (ovf_pin) hits++;
        end
        wr_en = 1'b0;
        check("R9 set wins over clear", 8'(hits > 0), 8'h01);
        check("R9 clear still acts", 8'(hits < 40), 8'h01);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule